// File: doc/BRIEF.md
# DDR2 Refresh and Self-Refresh Scheduler

This block sits beside a DDR2 command generator. It keeps the memory refreshed and controls the clock-enable line. A free-running interval counter adds one owed refresh to a debt count each period. While any refresh is owed, the block requests a command slot from the arbiter. When the arbiter grants the slot and reports that every bank is closed, the block fires a one-cycle refresh strobe and pays off one unit of debt. If the debt reaches its ceiling, an urgent flag tells the arbiter to put refresh ahead of normal traffic.

After each refresh, two status outputs close the command bus for the refresh recovery window. One of them gates reads and the other gates every other command. A system request moves the memory into self-refresh: the block issues a refresh strobe and drops clock-enable in that same cycle. Releasing the request raises clock-enable again. After that exit, non-read commands are held back for one delay and reads for a longer one. The debt is cleared and the interval counter starts again from zero. Clock-enable never changes level until it has held its current level for a minimum number of cycles.

Top module: `ddr2_rfsh_sched`

## Requirements
- R1: In reset, and right after it, the outputs are: cke high, ref_req low, ref_urgent low, ref_cmd low, cmd_ok high and rd_ok high.
- R2: While clock-enable is high, the interval counter adds one owed refresh every REFI_CYC cycles. The first one is added REFI_CYC cycles after reset is released. ref_req is high whenever cmd_ok is high and at least one refresh is owed.
- R3: A slot is taken only on a clock edge that sees ref_req, ref_gnt and all_precharged all high. ref_cmd is then high for the one following cycle and the debt drops by one. A grant while all_precharged is low has no effect.
- R4: cmd_ok and rd_ok are low for exactly RFC_CYC cycles, starting with the cycle in which ref_cmd is high.
- R5: The debt saturates at DEBT_MAX, and a period that ends while the debt is at DEBT_MAX is lost. ref_urgent is high exactly while the debt equals DEBT_MAX and clock-enable is high.
- R6: While sr_req is high, clock-enable has been high for at least CKE_MIN cycles and cmd_ok is high, ref_req is raised. An accepted grant then gives ref_cmd high and cke low in the same cycle.
- R7: During self-refresh (cke low), the interval counter is paused, ref_req and ref_urgent are low, and cmd_ok and rd_ok are low.
- R8: Dropping sr_req during self-refresh raises cke at the first edge at which cke has been low for CKE_MIN cycles. From the cycle in which cke rises, cmd_ok stays low for XSNR_CYC cycles and rd_ok stays low for XSRD_CYC cycles.
- R9: On self-refresh exit, the debt is cleared and the interval counter restarts from zero. The next ref_req comes REFI_CYC cycles after cke rises.
- R10: cke never holds a level for fewer than CKE_MIN cycles, even when sr_req is dropped right after entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt | input | 1 | Arbiter grants the requested command slot |
| all_precharged | input | 1 | All banks are closed |
| sr_req | input | 1 | System asks to stay in self-refresh |
| ref_req | output | 1 | Request for a refresh slot |
| ref_urgent | output | 1 | Debt at its ceiling; refresh outranks traffic |
| ref_cmd | output | 1 | One-cycle refresh command strobe |
| cke | output | 1 | Clock-enable to the memory |
| cmd_ok | output | 1 | Non-read commands may be issued |
| rd_ok | output | 1 | Read commands may be issued |

## Verification
The scheduler is exercised with a grant that arrives while the banks are still open and then once they close. This tells an accepted slot apart from an ignored one. It is also exercised with a long stretch without any grant, followed by a continuous grant. That pattern separates a saturating debt from one that keeps counting, because the number of strobes before ref_req drops differs by one. A long self-refresh stay checks that the interval counter stays paused, and that the debt and the counter are cleared on exit, because the timing of the first request after exit differs otherwise. A very short self-refresh request checks the minimum clock-enable hold.

// File: rtl/ddr2_rfsh_pkg.sv
package ddr2_rfsh_pkg;

    typedef enum logic {
        PH_RUN  = 1'b0,
        PH_SELF = 1'b1
    } phase_t;

    typedef struct packed {
        logic accept;   // slot taken this edge
        logic enter;    // slot used for self-refresh entry
        logic take;     // slot used for a plain refresh
        logic wake;     // self-refresh exit this edge
    } rf_evt_t;

    function automatic int unsigned bits_for(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rfsh_interval.sv
module rfsh_interval
    import ddr2_rfsh_pkg::*;
#(
    parameter int unsigned REFI_CYC = 2600,
    parameter int unsigned DEBT_MAX = 8,
    localparam int unsigned CW = bits_for(REFI_CYC - 1),
    localparam int unsigned DW = bits_for(DEBT_MAX)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          clr,
    input  logic          take,
    output logic [DW-1:0] debt
);
    logic [CW-1:0] cnt;
    logic          tick;

    assign tick = run && (cnt == CW'(REFI_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt  <= '0;
            debt <= '0;
        end else begin
            if (run) cnt <= tick ? '0 : cnt + 1'b1;
            unique case ({tick, take})
                2'b10:   if (debt != DW'(DEBT_MAX)) debt <= debt + 1'b1;
                2'b01:   if (debt != '0) debt <= debt - 1'b1;
                default: debt <= debt;
            endcase
        end
    end

    // R5
    debt_cap_chk: assert property (@(posedge clk) disable iff (rst)
        debt <= DW'(DEBT_MAX));

    // R7
    pause_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !clr) |=> $stable(debt));

endmodule

// File: rtl/rfsh_quiet.sv
module rfsh_quiet #(
    parameter int unsigned QW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [QW-1:0] val,
    output logic          idle
);
    logic [QW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)              left <= '0;
        else if (load)        left <= val;
        else if (left != '0)  left <= left - 1'b1;
    end

    assign idle = (left == '0);

    // R4
    quiet_load_chk: assert property (@(posedge clk) disable iff (rst)
        (load && val != '0) |=> !idle);

endmodule

// File: rtl/rfsh_cke_seq.sv
module rfsh_cke_seq
    import ddr2_rfsh_pkg::*;
#(
    parameter int unsigned CKE_MIN = 3,
    localparam int unsigned HW = bits_for(CKE_MIN)
) (
    input  logic clk,
    input  logic rst,
    input  logic enter,
    input  logic sr_req,
    output logic cke,
    output logic in_self,
    output logic hold_ok,
    output logic leave
);
    phase_t        ph;
    logic [HW-1:0] hold_cnt;

    assign hold_ok = (hold_cnt >= HW'(CKE_MIN));
    assign in_self = (ph == PH_SELF);
    assign leave   = in_self && !sr_req && hold_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_RUN;
            cke      <= 1'b1;
            hold_cnt <= HW'(CKE_MIN);
        end else if (enter && !in_self && hold_ok) begin
            ph       <= PH_SELF;
            cke      <= 1'b0;
            hold_cnt <= HW'(1);
        end else if (leave) begin
            ph       <= PH_RUN;
            cke      <= 1'b1;
            hold_cnt <= HW'(1);
        end else if (!hold_ok) begin
            hold_cnt <= hold_cnt + 1'b1;
        end
    end

    // independent run-length tracker for the hold check
    logic          chk_prev;
    logic [HW-1:0] chk_len;
    always_ff @(posedge clk) begin
        if (rst) begin
            chk_prev <= 1'b1;
            chk_len  <= HW'(CKE_MIN);
        end else begin
            chk_prev <= cke;
            if (cke != chk_prev)                 chk_len <= HW'(1);
            else if (chk_len < HW'(CKE_MIN))     chk_len <= chk_len + 1'b1;
        end
    end

    // R10
    cke_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cke != chk_prev) |-> (chk_len >= HW'(CKE_MIN)));

endmodule

// File: rtl/ddr2_rfsh_sched.sv
module ddr2_rfsh_sched
    import ddr2_rfsh_pkg::*;
#(
    parameter int unsigned REFI_CYC = 2600,
    parameter int unsigned RFC_CYC  = 35,
    parameter int unsigned XSNR_CYC = 39,
    parameter int unsigned XSRD_CYC = 200,
    parameter int unsigned CKE_MIN  = 3,
    parameter int unsigned DEBT_MAX = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_gnt,
    input  logic all_precharged,
    input  logic sr_req,
    output logic ref_req,
    output logic ref_urgent,
    output logic ref_cmd,
    output logic cke,
    output logic cmd_ok,
    output logic rd_ok
);
    localparam int unsigned DW = bits_for(DEBT_MAX);
    localparam int unsigned QW = bits_for(max3(RFC_CYC, XSNR_CYC, XSRD_CYC));

    logic [DW-1:0] debt;
    logic          in_self, hold_ok, leave, run, entry_ok;
    logic [1:0]    idle_v;
    rf_evt_t       evt;

    assign run      = !in_self;
    assign entry_ok = sr_req && hold_ok && run;
    assign cmd_ok   = run && idle_v[0];
    assign rd_ok    = run && idle_v[1];
    assign ref_req  = cmd_ok && ((debt != '0) || entry_ok);
    assign ref_urgent = run && (debt == DW'(DEBT_MAX));

    always_comb begin
        evt.accept = ref_req && ref_gnt && all_precharged;
        evt.enter  = evt.accept && entry_ok;
        evt.take   = evt.accept && !entry_ok;
        evt.wake   = leave;
    end

    always_ff @(posedge clk) begin
        if (rst) ref_cmd <= 1'b0;
        else     ref_cmd <= evt.accept;
    end

    rfsh_interval #(.REFI_CYC(REFI_CYC), .DEBT_MAX(DEBT_MAX)) u_interval (
        .clk(clk), .rst(rst), .run(run), .clr(evt.wake), .take(evt.take), .debt(debt)
    );

    rfsh_cke_seq #(.CKE_MIN(CKE_MIN)) u_cke (
        .clk(clk), .rst(rst), .enter(evt.enter), .sr_req(sr_req),
        .cke(cke), .in_self(in_self), .hold_ok(hold_ok), .leave(leave)
    );

    // lane 0 gates non-read commands, lane 1 gates reads
    for (genvar g = 0; g < 2; g++) begin : g_quiet
        localparam int unsigned WAKE_V = (g == 0) ? XSNR_CYC : XSRD_CYC;
        rfsh_quiet #(.QW(QW)) u_q (
            .clk(clk), .rst(rst),
            .load(evt.accept || evt.wake),
            .val(evt.wake ? QW'(WAKE_V) : QW'(RFC_CYC)),
            .idle(idle_v[g])
        );
    end

    // R4
    strobe_blackout_chk: assert property (@(posedge clk) disable iff (rst)
        ref_cmd |-> (!cmd_ok && !rd_ok));

    // R3
    strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
        ref_cmd |-> $past(ref_gnt && all_precharged));

    // R6
    enter_together_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cke) |-> ref_cmd);

    // R8
    wake_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cke) |-> (!cmd_ok && !rd_ok));

    // R5
    urgent_req_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_urgent && cmd_ok) |-> ref_req);

    // R7
    self_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cke |-> (!ref_req && !ref_urgent && !cmd_ok && !rd_ok));

endmodule

// File: tb/tb_ddr2_rfsh_sched.sv
module tb_ddr2_rfsh_sched;
    localparam int REFI = 40, RFC = 6, XSNR = 8, XSRD = 20, CMIN = 3, DMAX = 8;
    localparam int S_REQ = 0, S_CMD = 1, S_CKE = 2, S_CMDOK = 3, S_RDOK = 4, S_URG = 5;

    logic clk = 1'b0, rst = 1'b1;
    logic ref_gnt = 1'b0, all_precharged = 1'b1, sr_req = 1'b0;
    logic ref_req, ref_urgent, ref_cmd, cke, cmd_ok, rd_ok;

    always #4 clk = ~clk;

    ddr2_rfsh_sched #(.REFI_CYC(REFI), .RFC_CYC(RFC), .XSNR_CYC(XSNR), .XSRD_CYC(XSRD),
                      .CKE_MIN(CMIN), .DEBT_MAX(DMAX)) dut (
        .clk(clk), .rst(rst), .ref_gnt(ref_gnt), .all_precharged(all_precharged),
        .sr_req(sr_req), .ref_req(ref_req), .ref_urgent(ref_urgent), .ref_cmd(ref_cmd),
        .cke(cke), .cmd_ok(cmd_ok), .rd_ok(rd_ok)
    );

    typedef struct {
        int    cyc;
        int    sig;
        bit    val;
        string tag;
    } exp_t;

    exp_t q[$];
    int cyc = 0, checks = 0, errors = 0, pulses = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic bit pick(input int s);
        case (s)
            S_REQ:   return ref_req;
            S_CMD:   return ref_cmd;
            S_CKE:   return cke;
            S_CMDOK: return cmd_ok;
            S_RDOK:  return rd_ok;
            default: return ref_urgent;
        endcase
    endfunction

    // monitor: compares queued expectations against the ports
    always @(negedge clk) begin
        if (cyc >= 404 && cyc <= 470 && ref_cmd) pulses++;
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].cyc <= cyc) begin
                checks++;
                if (q[i].cyc < cyc || pick(q[i].sig) !== q[i].val) begin
                    errors++;
                    $display("FAIL %s sig%0d cycle %0d: actual %0b expected %0b",
                             q[i].tag, q[i].sig, q[i].cyc, pick(q[i].sig), q[i].val);
                end
                q.delete(i);
            end
        end
    end

    task automatic expect_at(input int c, input int s, input bit v, input string tag);
        exp_t e;
        e.cyc = c; e.sig = s; e.val = v; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) begin
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        // R1 reset values, rst held through edge 3
        expect_at(3, S_CKE, 1, "R1");   expect_at(3, S_REQ, 0, "R1");
        expect_at(3, S_CMD, 0, "R1");   expect_at(3, S_CMDOK, 1, "R1");
        expect_at(3, S_RDOK, 1, "R1");  expect_at(3, S_URG, 0, "R1");
        wait_until(3);
        rst = 1'b0;
        // R2 first owed refresh REFI cycles after release
        expect_at(3 + REFI - 1, S_REQ, 0, "R2");
        expect_at(3 + REFI, S_REQ, 1, "R2");
        wait_until(43);
        ref_gnt = 1'b1; all_precharged = 1'b0;
        // R3 grant ignored while banks open
        expect_at(44, S_CMD, 0, "R3"); expect_at(44, S_REQ, 1, "R3");
        expect_at(44, S_CMDOK, 1, "R3");
        wait_until(44);
        all_precharged = 1'b1;
        expect_at(45, S_CMD, 1, "R3"); expect_at(45, S_REQ, 0, "R3");
        expect_at(45, S_CMDOK, 0, "R4"); expect_at(45, S_RDOK, 0, "R4");
        wait_until(45);
        ref_gnt = 1'b0;
        expect_at(46, S_CMD, 0, "R3");
        expect_at(45 + RFC - 1, S_CMDOK, 0, "R4"); expect_at(45 + RFC, S_CMDOK, 1, "R4");
        expect_at(45 + RFC - 1, S_RDOK, 0, "R4");  expect_at(45 + RFC, S_RDOK, 1, "R4");
        // R5 debt reaches the ceiling at the ninth period end
        expect_at(362, S_URG, 0, "R5"); expect_at(363, S_URG, 1, "R5");
        wait_until(404);
        ref_gnt = 1'b1;
        expect_at(405, S_URG, 0, "R5");
        expect_at(461, S_CMD, 1, "R5");
        expect_at(467, S_REQ, 0, "R5");
        wait_until(467);
        ref_gnt = 1'b0;
        wait_until(470);
        checks++;
        if (pulses != 9) begin
            errors++;
            $display("FAIL R5 strobes while draining: actual %0d expected 9", pulses);
        end
        // R6 self-refresh entry with one refresh owed
        expect_at(483, S_REQ, 1, "R2");
        wait_until(485);
        sr_req = 1'b1;
        wait_until(490);
        ref_gnt = 1'b1;
        expect_at(491, S_CKE, 0, "R6"); expect_at(491, S_CMD, 1, "R6");
        wait_until(491);
        ref_gnt = 1'b0;
        expect_at(492, S_CMD, 0, "R6"); expect_at(492, S_CMDOK, 0, "R7");
        // R7 quiet while in self-refresh
        expect_at(590, S_REQ, 0, "R7");  expect_at(590, S_URG, 0, "R7");
        expect_at(590, S_CMDOK, 0, "R7"); expect_at(590, S_RDOK, 0, "R7");
        expect_at(590, S_CKE, 0, "R7");
        wait_until(600);
        sr_req = 1'b0;
        // R8 exit delays
        expect_at(601, S_CKE, 1, "R8");
        expect_at(601 + XSNR - 1, S_CMDOK, 0, "R8"); expect_at(601 + XSNR, S_CMDOK, 1, "R8");
        expect_at(601 + XSNR, S_RDOK, 0, "R8");
        expect_at(601 + XSRD - 1, S_RDOK, 0, "R8"); expect_at(601 + XSRD, S_RDOK, 1, "R8");
        // R9 debt cleared, interval restarted
        expect_at(620, S_REQ, 0, "R9");
        expect_at(601 + REFI - 1, S_REQ, 0, "R9"); expect_at(601 + REFI, S_REQ, 1, "R9");
        wait_until(650);
        sr_req = 1'b1; ref_gnt = 1'b1;
        expect_at(651, S_CKE, 0, "R6");
        wait_until(651);
        sr_req = 1'b0; ref_gnt = 1'b0;
        // R10 low level held for CKE_MIN cycles
        expect_at(652, S_CKE, 0, "R10"); expect_at(653, S_CKE, 0, "R10");
        expect_at(654, S_CKE, 1, "R10");
        wait_until(700);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        while (cyc < 200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule